// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block is a direct-mapped cache of single-word lines that sits between a processor-side request port and a memory-side port. Each line holds a valid flag, an address tag and one data word. A byte address is split into a tag, a line index and a byte-in-word field. The byte-in-word field is ignored because every access moves a whole word.

Loads look up the indexed line. A hit answers on the next cycle. A miss fetches the word from memory, installs it with its new tag and then answers. Stores take no lookup at all. The indexed line is overwritten with the new tag and word and marked valid, and the same store is passed to the memory port in the same cycle. Memory therefore always holds every stored word, and a line never needs to be copied back. Since there is only one slot per index, that slot is always the one replaced, and no replacement state exists.

Both ports use valid/ready handshakes. The processor is held off while a fetch is outstanding, and a store is accepted only in the cycle that memory accepts it. The default build has 1K lines; a 64 KB data store is obtained with `INDEX_W = 14`, which leaves a 16-bit tag for 32-bit addresses.

Top module: `wt_dm_cache`

## Requirements
- R1: An address divides into tag = addr[ADDR_W-1:INDEX_W+2], index = addr[INDEX_W+1:2] and offset = addr[1:0]. The offset never changes which word is read. A fetch address has its two low bits forced to zero. Two addresses that differ only in a high tag bit are different lines.
- R2: Reset clears every valid flag. After reset, cpu_rsp_valid and mem_req_valid are 0, cpu_req_ready is 1, and the first load to each index misses.
- R3: An accepted store writes its tag and word into the indexed line and marks it valid, whatever the line held before. A later load to that address hits and returns the stored word.
- R4: Every accepted store appears on the memory port in the same cycle, with mem_req_write = 1, the word-aligned address and the store data. A store is accepted only while mem_req_ready is 1.
- R5: A load whose indexed line is valid with an equal tag is answered with cpu_rsp_valid on the cycle after acceptance, carrying the stored word, and issues no memory request.
- R6: A load miss issues exactly one fetch (mem_req_write = 0). The word returned with mem_rsp_valid is delivered on cpu_rsp_rdata on the following cycle and is installed in the indexed line, so the same load then hits.
- R7: A load or store with a different tag at an occupied index replaces that line. A load of the former address then misses.
- R8: cpu_req_ready stays 0 from the cycle after a miss is accepted until the fetched word has been delivered.
- R9: A fetch request that is not accepted is held on the next cycle with the same address.
- R10: A store to the same index issued in the cycle right after a refill response overwrites the refilled line. A load of the store address then hits with the store data, and a load of the refilled address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Store word |
| cpu_rsp_valid | output | 1 | Load result present (one cycle) |
| cpu_rsp_rdata | output | DATA_W | Load result word |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = fetch |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | DATA_W | Store word |
| mem_rsp_valid | input | 1 | Fetched word present |
| mem_rsp_rdata | input | DATA_W | Fetched word |

## Verification
The bench sweeps every index of a 16-line build through cold misses, offset-varied hits, tag-replacing stores and conflicting loads. It uses a memory model whose ready line and response latency are varied. A design that checked the tag before a store would leave stale words, so later loads would return them. A design that compared only part of the tag would hit on the address with a flipped high bit. A refill that raced a store issued in the very next cycle would let the fetched word or tag win, so the store address would miss or the refilled address would hit. A design that dropped or re-issued a held fetch would show the wrong fetch count or a changed address while memory stalls.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2
   } wtc_state_e;

   function automatic int tag_bits(input int addr_w, input int index_w, input int offset_w);
      return addr_w - index_w - offset_w;
   endfunction

endpackage

// File: rtl/wtc_addr_split.sv
module wtc_addr_split #(
   parameter int ADDR_W   = 32,
   parameter int INDEX_W  = 10,
   parameter int OFFSET_W = 2,
   parameter int TAG_W    = 20
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [TAG_W-1:0]   tag,
   output logic [INDEX_W-1:0] index,
   output logic [ADDR_W-1:0]  word_addr
);

   logic unused_offset;

   assign tag           = addr[ADDR_W-1 -: TAG_W];
   assign index         = addr[OFFSET_W +: INDEX_W];
   assign word_addr     = {addr[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};
   assign unused_offset = ^addr[OFFSET_W-1:0];

endmodule

// File: rtl/wtc_array.sv
module wtc_array #(
   parameter int INDEX_W = 10,
   parameter int TAG_W   = 20,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] rd_idx,
   output logic               rd_valid,
   output logic [TAG_W-1:0]   rd_tag,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [DATA_W-1:0]  wr_data
);

   localparam int DEPTH = 1 << INDEX_W;

   logic [DEPTH-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[e] <= 1'b0;
         end else if (wr_en && (wr_idx == INDEX_W'(e))) begin
            vld_q[e] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == INDEX_W'(e))) begin
            tag_q[e]  <= wr_tag;
            data_q[e] <= wr_data;
         end
      end
   end

   assign rd_valid = vld_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];

   // R3
   wr_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(wr_idx)]);

   // R3
   wr_data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_idx == wr_idx) |=> ($past(rd_idx) != rd_idx) || (rd_data == $past(wr_data)) || $past(!wr_en));

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
   import wtc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int INDEX_W = 10,
   parameter int TAG_W   = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req_valid,
   output logic               cpu_req_ready,
   input  logic               cpu_req_write,
   input  logic [ADDR_W-1:0]  req_word_addr,
   input  logic [INDEX_W-1:0] req_idx,
   input  logic [TAG_W-1:0]   req_tag,
   input  logic [DATA_W-1:0]  cpu_req_wdata,
   output logic               cpu_rsp_valid,
   output logic [DATA_W-1:0]  cpu_rsp_rdata,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_req_write,
   output logic [ADDR_W-1:0]  mem_req_addr,
   output logic [DATA_W-1:0]  mem_req_wdata,
   input  logic               mem_rsp_valid,
   input  logic [DATA_W-1:0]  mem_rsp_rdata,
   input  logic               ent_valid,
   input  logic [TAG_W-1:0]   ent_tag,
   input  logic [DATA_W-1:0]  ent_data,
   output logic               arr_wr_en,
   output logic [INDEX_W-1:0] arr_wr_idx,
   output logic [TAG_W-1:0]   arr_wr_tag,
   output logic [DATA_W-1:0]  arr_wr_data
);

   wtc_state_e         state_q;
   logic [ADDR_W-1:0]  miss_addr_q;
   logic [INDEX_W-1:0] miss_idx_q;
   logic [TAG_W-1:0]   miss_tag_q;
   logic               idle;
   logic               hit;
   logic               cpu_acc;
   logic               fill;

   always_comb begin
      idle          = (state_q == ST_IDLE);
      hit           = ent_valid && (ent_tag == req_tag);
      cpu_req_ready = idle && (!cpu_req_write || mem_req_ready);
      cpu_acc       = cpu_req_valid && cpu_req_ready;
      fill          = (state_q == ST_WAIT) && mem_rsp_valid;

      mem_req_valid = (state_q == ST_FETCH) || (idle && cpu_req_valid && cpu_req_write);
      mem_req_write = idle;
      mem_req_addr  = idle ? req_word_addr : miss_addr_q;
      mem_req_wdata = cpu_req_wdata;

      arr_wr_en     = (cpu_acc && cpu_req_write) || fill;
      arr_wr_idx    = fill ? miss_idx_q : req_idx;
      arr_wr_tag    = fill ? miss_tag_q : req_tag;
      arr_wr_data   = fill ? mem_rsp_rdata : cpu_req_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         miss_addr_q   <= '0;
         miss_idx_q    <= '0;
         miss_tag_q    <= '0;
         cpu_rsp_valid <= 1'b0;
         cpu_rsp_rdata <= '0;
      end else begin
         cpu_rsp_valid <= (cpu_acc && !cpu_req_write && hit) || fill;
         if (fill) begin
            cpu_rsp_rdata <= mem_rsp_rdata;
         end else if (cpu_acc && !cpu_req_write && hit) begin
            cpu_rsp_rdata <= ent_data;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (cpu_acc && !cpu_req_write && !hit) begin
                  state_q     <= ST_FETCH;
                  miss_addr_q <= req_word_addr;
                  miss_idx_q  <= req_idx;
                  miss_tag_q  <= req_tag;
               end
            end
            ST_FETCH: begin
               if (mem_req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write && !mem_req_ready)
      |=> (mem_req_valid && !mem_req_write && $stable(mem_req_addr)));

   // R8
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> !cpu_req_ready);

   // R6
   fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && mem_rsp_valid)
      |=> (cpu_rsp_valid && cpu_rsp_rdata == $past(mem_rsp_rdata)));

   // R4
   store_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && cpu_req_ready && cpu_req_write)
      |-> (mem_req_valid && mem_req_ready && mem_req_write && mem_req_wdata == cpu_req_wdata));

   // R5
   hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_acc && !cpu_req_write && ent_valid && ent_tag == req_tag)
      |=> (cpu_rsp_valid && cpu_rsp_rdata == $past(ent_data) && !(mem_req_valid && !mem_req_write)));

endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int INDEX_W  = 10,
   parameter int OFFSET_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_rsp_valid,
   output logic [DATA_W-1:0] cpu_rsp_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata
);

   localparam int TAG_W = wtc_pkg::tag_bits(ADDR_W, INDEX_W, OFFSET_W);

   if (TAG_W < 1) begin : g_bad_split
      $error("wt_dm_cache: index and offset leave no tag bits");
   end
   if (OFFSET_W < 1) begin : g_bad_offset
      $error("wt_dm_cache: OFFSET_W must be at least 1");
   end
   if (DATA_W != (8 << OFFSET_W) / 2 * 2 && DATA_W != (8 << OFFSET_W)) begin : g_bad_word
      $error("wt_dm_cache: DATA_W must equal the word addressed by OFFSET_W");
   end

   logic [TAG_W-1:0]   req_tag;
   logic [INDEX_W-1:0] req_idx;
   logic [ADDR_W-1:0]  req_word_addr;
   logic               ent_valid;
   logic [TAG_W-1:0]   ent_tag;
   logic [DATA_W-1:0]  ent_data;
   logic               arr_wr_en;
   logic [INDEX_W-1:0] arr_wr_idx;
   logic [TAG_W-1:0]   arr_wr_tag;
   logic [DATA_W-1:0]  arr_wr_data;

   wtc_addr_split #(
      .ADDR_W   (ADDR_W),
      .INDEX_W  (INDEX_W),
      .OFFSET_W (OFFSET_W),
      .TAG_W    (TAG_W)
   ) split_i (
      .addr      (cpu_req_addr),
      .tag       (req_tag),
      .index     (req_idx),
      .word_addr (req_word_addr)
   );

   wtc_array #(
      .INDEX_W (INDEX_W),
      .TAG_W   (TAG_W),
      .DATA_W  (DATA_W)
   ) array_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (req_idx),
      .rd_valid (ent_valid),
      .rd_tag   (ent_tag),
      .rd_data  (ent_data),
      .wr_en    (arr_wr_en),
      .wr_idx   (arr_wr_idx),
      .wr_tag   (arr_wr_tag),
      .wr_data  (arr_wr_data)
   );

   wtc_ctrl #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .INDEX_W (INDEX_W),
      .TAG_W   (TAG_W)
   ) ctrl_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req_valid (cpu_req_valid),
      .cpu_req_ready (cpu_req_ready),
      .cpu_req_write (cpu_req_write),
      .req_word_addr (req_word_addr),
      .req_idx       (req_idx),
      .req_tag       (req_tag),
      .cpu_req_wdata (cpu_req_wdata),
      .cpu_rsp_valid (cpu_rsp_valid),
      .cpu_rsp_rdata (cpu_rsp_rdata),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_rdata (mem_rsp_rdata),
      .ent_valid     (ent_valid),
      .ent_tag       (ent_tag),
      .ent_data      (ent_data),
      .arr_wr_en     (arr_wr_en),
      .arr_wr_idx    (arr_wr_idx),
      .arr_wr_tag    (arr_wr_tag),
      .arr_wr_data   (arr_wr_data)
   );

   // R1
   fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[OFFSET_W-1:0] == '0));

   // R2
   rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |-> $past(cpu_req_valid || mem_rsp_valid));

endmodule

// File: tb/wt_dm_cache_tb_top.sv
module wt_dm_cache_tb_top;

   localparam int IW = 4;
   localparam int NE = 1 << IW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req_valid = 1'b0;
   logic        cpu_req_ready;
   logic        cpu_req_write = 1'b0;
   logic [31:0] cpu_req_addr = '0;
   logic [31:0] cpu_req_wdata = '0;
   logic        cpu_rsp_valid;
   logic [31:0] cpu_rsp_rdata;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic        mem_req_write;
   logic [31:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;

   always #10 clk = ~clk;

   wt_dm_cache #(.ADDR_W(32), .DATA_W(32), .INDEX_W(IW), .OFFSET_W(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
      .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
      .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
      .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory model
   logic [31:0] mem_model [4096];
   int          ready_mode = 0;
   int          lat = 1;
   int          cyc = 0;
   logic        pend = 1'b0;
   int          cnt = 0;
   logic [11:0] pend_w = '0;
   int          n_fetch = 0;
   int          n_store = 0;
   logic [31:0] last_fetch_addr = '0;
   logic [31:0] last_store_addr = '0;
   logic [31:0] last_store_data = '0;
   logic        prev_stall = 1'b0;
   logic [31:0] prev_addr = '0;
   int          hold_err = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      if (rst_n && prev_stall && !(mem_req_valid && !mem_req_write && mem_req_addr == prev_addr))
         hold_err++;
      prev_stall <= rst_n && mem_req_valid && !mem_req_write && !mem_req_ready;
      prev_addr  <= mem_req_addr;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            mem_model[mem_req_addr[13:2]] = mem_req_wdata;
            n_store++;
            last_store_addr = mem_req_addr;
            last_store_data = mem_req_wdata;
         end else begin
            pend   <= 1'b1;
            cnt    <= lat;
            pend_w <= mem_req_addr[13:2];
            n_fetch++;
            last_fetch_addr = mem_req_addr;
         end
      end
      if (pend) begin
         if (cnt == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_rdata <= mem_model[pend_w];
            pend <= 1'b0;
         end else begin
            cnt <= cnt - 1;
         end
      end
      mem_req_ready <= (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
   end

   // bench view of the cache, from the requirements
   logic          bv [NE];
   logic [25:0]   bt [NE];

   function automatic logic [31:0] mk(input int tag, input int idx, input int off);
      return (32'(tag) << 6) | (32'(idx) << 2) | 32'(off);
   endfunction

   task automatic cpu_read(input logic [31:0] a, output logic [31:0] d,
                           output int nf, output int stall_bad);
      int f0;
      f0 = n_fetch;
      stall_bad = 0;
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = a;
      #1;
      while (!cpu_req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0;
      while (!cpu_rsp_valid) begin
         if (cpu_req_ready) stall_bad++;
         @(negedge clk);
      end
      d  = cpu_rsp_rdata;
      nf = n_fetch - f0;
   endtask

   task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, input bit now);
      if (!now) @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = a; cpu_req_wdata = d;
      #1;
      while (!cpu_req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
   endtask

   task automatic rd_chk(input logic [31:0] a, input string req);
      logic [31:0] d;
      logic [31:0] expd;
      int nf, sb;
      bit  ehit;
      ehit = bv[a[5:2]] && (bt[a[5:2]] == a[31:6]);
      cpu_read(a, d, nf, sb);
      expd = mem_model[a[13:2]];
      chk(d == expd, req, "load data", d, expd);
      chk(nf == (ehit ? 0 : 1), req, "fetch count", 32'(nf), ehit ? 32'd0 : 32'd1);
      if (!ehit) begin
         chk(sb == 0, "R8", "ready during miss", 32'(sb), 32'd0);
         chk(last_fetch_addr == {a[31:2], 2'b00}, "R1", "fetch address", last_fetch_addr, {a[31:2], 2'b00});
      end
      bv[a[5:2]] = 1'b1;
      bt[a[5:2]] = a[31:6];
   endtask

   task automatic wr_chk(input logic [31:0] a, input logic [31:0] d, input bit now);
      int s0;
      s0 = n_store;
      cpu_write(a, d, now);
      chk(n_store == s0 + 1, "R4", "store count", 32'(n_store - s0), 32'd1);
      chk(last_store_addr == {a[31:2], 2'b00} && last_store_data == d, "R4",
          "store forwarded", last_store_data, d);
      bv[a[5:2]] = 1'b1;
      bt[a[5:2]] = a[31:6];
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem_model[i] = (32'(i) * 32'h0100_0193) ^ 32'hC0DE_0000;
      for (int i = 0; i < NE; i++) begin bv[i] = 1'b0; bt[i] = '0; end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL R6 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R2 reset state
      chk(cpu_rsp_valid == 1'b0, "R2", "rsp_valid in reset", 32'(cpu_rsp_valid), 32'd0);
      chk(mem_req_valid == 1'b0, "R2", "mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
      chk(cpu_req_ready == 1'b1, "R2", "ready in reset", 32'(cpu_req_ready), 32'd1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 / R6: cold misses on every index
      for (int i = 0; i < NE; i++) rd_chk(mk(3, i, 0), "R6");
      // R5 / R1: hits with varied offsets
      for (int i = 0; i < NE; i++) rd_chk(mk(3, i, i % 4), "R5");

      // R3 / R4 / R7 under memory stalls and longer latency
      ready_mode = 1; lat = 3;
      for (int i = 0; i < NE; i++) begin
         wr_chk(mk(5, i, 3), 32'hA500_0000 | 32'(i), 1'b0);
         rd_chk(mk(5, i, 0), "R3");
         rd_chk(mk(3, i, 1), "R7");
         rd_chk(mk(3, i, 2), "R5");
      end

      // R1: a high tag bit separates two lines
      rd_chk(32'h0000_0040, "R1");
      rd_chk(32'h8000_0040, "R1");
      rd_chk(32'h0000_0040, "R1");

      // R10: store right after a refill to the same index
      ready_mode = 0; lat = 1;
      repeat (3) @(negedge clk);
      for (int i = 0; i < NE; i += 3) begin
         rd_chk(mk(7, i, 0), "R10");
         wr_chk(mk(9, i, 0), 32'h9900_0000 | 32'(i), 1'b1);
         rd_chk(mk(9, i, 0), "R10");
         rd_chk(mk(7, i, 0), "R10");
      end

      // R9: held fetches under stalls
      chk(hold_err == 0, "R9", "fetch held while stalled", 32'(hold_err), 32'd0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule